// File: doc/BRIEF.md
# Dual-Domain Gear Ratio Dividers

This block produces two slow comparison signals of equal frequency from two clocks that run at different rates. The controller-side lane divides its clock by M and the memory-side lane divides its clock by N. M and N are taken together as a pair from a small gear-ratio table, chosen so that the controller frequency divided by M equals the memory frequency divided by N. A downstream phase comparator can then line up the rising edges of the two outputs.

The memory-side clock is the channel bus clock divided by four. The gear ratio is the controller frequency over the memory frequency. Each lane provides a square wave and a one-cycle marker on the cycle where its count restarts. Only those rising edges are meant to be compared, because the two waves may have different duty cycles. A lane whose enable is low holds both of its outputs low. Each lane loads a new ratio code on its own load strobe. The new divisor is applied when the lane reaches its next terminal count.

Top module: `gear_ratio_div`

## Requirements
- R1: After a synchronous reset (active-low, per lane), the wave, marker and error outputs of the lane are low. The lane divides by 4, which is the divisor of ratio code 0.
- R2: The 3-bit ratio code selects the (M, N) pair as follows. Code 0 gives 4/4 (ratio 1.0). Code 1 gives 4/3 (1.33). Code 2 gives 3/2 (1.5). Code 3 gives 4/2 (2.0). Code 4 gives 2/2 (1.0). Code 5 gives 8/6 (1.33). The controller lane uses M and the memory lane uses N.
- R3: When the controller clock period times M equals the memory clock period times N, the two lanes' markers repeat at the same time interval.
- R4: The marker is high for exactly one cycle each time the lane count restarts, and it occurs once every D cycles, where D is the active divisor. The wave is high in every cycle in which the marker is high, so the wave rises together with the marker.
- R5: For each period of D cycles, the wave is high for the first floor(D/2) cycles. For odd D the duty cycle is therefore below one half. For D = 1 the wave stays high.
- R6: The enable is registered. In the cycle after the enable is sampled low, the wave and marker are low, and the count is held at its start. After the enable is sampled high again, the first enabled cycle carries a marker.
- R7: A load pulse captures the divisor for the current code as pending. While the lane runs, the pending divisor takes effect at the next terminal count, and the count restarts from zero. While the lane is disabled, the pending divisor takes effect at once.
- R8: Codes 6 and 7 are unsupported. Loading one of them sets the lane's divisor to 1 and raises the error output in the cycle after the load. Loading a supported code clears the error output. Without a load, the error output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Controller-side clock |
| ctl_rst_n | input | 1 | Synchronous active-low reset, controller lane |
| ctl_en | input | 1 | Controller lane enable |
| ctl_load | input | 1 | Controller lane ratio load strobe |
| mem_clk | input | 1 | Memory-side clock |
| mem_rst_n | input | 1 | Synchronous active-low reset, memory lane |
| mem_en | input | 1 | Memory lane enable |
| mem_load | input | 1 | Memory lane ratio load strobe |
| ratio_sel | input | SEL_W | Gear-ratio code, held stable around each load |
| ctl_div_wave | output | 1 | Controller divided square wave |
| ctl_div_tick | output | 1 | Controller rising-edge marker |
| ctl_sel_err | output | 1 | Controller lane unsupported-code flag |
| mem_div_wave | output | 1 | Memory divided square wave |
| mem_div_tick | output | 1 | Memory rising-edge marker |
| mem_sel_err | output | 1 | Memory lane unsupported-code flag |

## Verification
The bench runs every table code with clock periods scaled so that the two markers should repeat at equal time intervals. A lane that took the wrong column of the table, or was off by one in its count, shows a different interval from its partner.

Odd divisors and the divisor of 1 test the wave's high-time rule. An exactly half-duty rounding would add or drop a high cycle in a fixed window.

A load issued while the lane runs must not shorten the current period. A design that switched divisors at once would misplace a marker in the per-cycle model comparison. A load issued while the lane is disabled must apply at once.

The enable and unsupported-code paths are also checked. A wave that leaks while disabled, a restart without a marker, or an error flag that sticks after a good code would each be reported.

// File: rtl/gear_ratio_pkg.sv
`timescale 1ns/1ps
package gear_ratio_pkg;

   // Controller-side divisor for a ratio code; unsupported codes divide by 1.
   function automatic int unsigned m_div(input int unsigned code);
      case (code)
         0: return 4;
         1: return 4;
         2: return 3;
         3: return 4;
         4: return 2;
         5: return 8;
         default: return 1;
      endcase
   endfunction

   // Memory-side divisor for a ratio code; unsupported codes divide by 1.
   function automatic int unsigned n_div(input int unsigned code);
      case (code)
         0: return 4;
         1: return 3;
         2: return 2;
         3: return 2;
         4: return 2;
         5: return 6;
         default: return 1;
      endcase
   endfunction

   function automatic bit ratio_ok(input int unsigned code);
      return code < 6;
   endfunction

endpackage

// File: rtl/gear_div_lane.sv
`timescale 1ns/1ps
module gear_div_lane #(
   parameter int SEL_W  = 3,
   parameter int CNT_W  = 4,
   parameter bit IS_MEM = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             load,
   input  logic [SEL_W-1:0] sel,
   output logic             wave,
   output logic             tick,
   output logic             err
);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] RESET_DIV = CNT_W'(4);

   logic [CNT_W-1:0] cur_div, pend_div, cnt, lookup, half;
   logic             pend_v, en_r, err_r, terminal, restart;

   // Column of the gear table chosen by lane side.
   generate
      if (IS_MEM) begin : g_n_col
         assign lookup = CNT_W'(gear_ratio_pkg::n_div(int'(sel)));
      end else begin : g_m_col
         assign lookup = CNT_W'(gear_ratio_pkg::m_div(int'(sel)));
      end
   endgenerate

   assign terminal = (cnt == cur_div - ONE);
   assign restart  = !en_r || terminal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_div  <= RESET_DIV;
         pend_div <= RESET_DIV;
         pend_v   <= 1'b0;
         cnt      <= '0;
         en_r     <= 1'b0;
         err_r    <= 1'b0;
      end else begin
         en_r <= en;
         if (restart) begin
            cnt <= '0;
            if (pend_v) begin
               cur_div <= pend_div;
               pend_v  <= 1'b0;
            end
         end else begin
            cnt <= cnt + ONE;
         end
         if (load) begin
            pend_div <= lookup;
            pend_v   <= 1'b1;
            err_r    <= !gear_ratio_pkg::ratio_ok(int'(sel));
         end
      end
   end

   assign half = (cur_div == ONE) ? ONE : (cur_div >> 1);
   assign wave = en_r && (cnt < half);
   assign tick = en_r && (cnt == '0);
   assign err  = err_r;

endmodule

// File: rtl/gear_ratio_div.sv
`timescale 1ns/1ps
module gear_ratio_div #(
   parameter int SEL_W = 3,
   parameter int CNT_W = 4
) (
   input  logic             ctl_clk,
   input  logic             ctl_rst_n,
   input  logic             ctl_en,
   input  logic             ctl_load,
   input  logic             mem_clk,
   input  logic             mem_rst_n,
   input  logic             mem_en,
   input  logic             mem_load,
   input  logic [SEL_W-1:0] ratio_sel,
   output logic             ctl_div_wave,
   output logic             ctl_div_tick,
   output logic             ctl_sel_err,
   output logic             mem_div_wave,
   output logic             mem_div_tick,
   output logic             mem_sel_err
);
   localparam int MAX_DIV = 8;

   if (CNT_W < $clog2(MAX_DIV + 1)) begin : g_cnt_w_chk
      $error("CNT_W too narrow for the largest gear divisor");
   end
   if (SEL_W < 3) begin : g_sel_w_chk
      $error("SEL_W must cover eight ratio codes");
   end

   gear_div_lane #(.SEL_W(SEL_W), .CNT_W(CNT_W), .IS_MEM(1'b0)) u_ctl_lane (
      .clk(ctl_clk), .rst_n(ctl_rst_n), .en(ctl_en), .load(ctl_load),
      .sel(ratio_sel), .wave(ctl_div_wave), .tick(ctl_div_tick), .err(ctl_sel_err)
   );

   gear_div_lane #(.SEL_W(SEL_W), .CNT_W(CNT_W), .IS_MEM(1'b1)) u_mem_lane (
      .clk(mem_clk), .rst_n(mem_rst_n), .en(mem_en), .load(mem_load),
      .sel(ratio_sel), .wave(mem_div_wave), .tick(mem_div_tick), .err(mem_sel_err)
   );

endmodule

// File: rtl/gear_ratio_div_chk.sv
`timescale 1ns/1ps
module gear_ratio_div_chk #(
   parameter int SEL_W = 3
) (
   input logic             ctl_clk,
   input logic             ctl_rst_n,
   input logic             ctl_en,
   input logic             ctl_load,
   input logic             mem_clk,
   input logic             mem_rst_n,
   input logic             mem_en,
   input logic             mem_load,
   input logic [SEL_W-1:0] ratio_sel,
   input logic             ctl_div_wave,
   input logic             ctl_div_tick,
   input logic             ctl_sel_err,
   input logic             mem_div_wave,
   input logic             mem_div_tick,
   input logic             mem_sel_err
);
   p_ctl_reset_r1: assert property (@(posedge ctl_clk)
      !ctl_rst_n |=> (!ctl_div_wave && !ctl_div_tick && !ctl_sel_err));
   p_mem_reset_r1: assert property (@(posedge mem_clk)
      !mem_rst_n |=> (!mem_div_wave && !mem_div_tick && !mem_sel_err));

   p_ctl_tick_wave_r4: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
      ctl_div_tick |-> ctl_div_wave);
   p_mem_tick_wave_r4: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
      mem_div_tick |-> mem_div_wave);

   p_ctl_idle_low_r6: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
      !$past(ctl_en) |-> (!ctl_div_wave && !ctl_div_tick));
   p_mem_idle_low_r6: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
      !$past(mem_en) |-> (!mem_div_wave && !mem_div_tick));

   p_ctl_err_set_r8: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
      $past(ctl_load) |-> (ctl_sel_err == !gear_ratio_pkg::ratio_ok(int'($past(ratio_sel)))));
   p_mem_err_set_r8: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
      $past(mem_load) |-> (mem_sel_err == !gear_ratio_pkg::ratio_ok(int'($past(ratio_sel)))));

   p_ctl_err_hold_r8: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
      !$past(ctl_load) |-> $stable(ctl_sel_err));
   p_mem_err_hold_r8: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
      !$past(mem_load) |-> $stable(mem_sel_err));
endmodule

bind gear_ratio_div gear_ratio_div_chk #(.SEL_W(SEL_W)) u_gear_chk (
   .ctl_clk(ctl_clk), .ctl_rst_n(ctl_rst_n), .ctl_en(ctl_en), .ctl_load(ctl_load),
   .mem_clk(mem_clk), .mem_rst_n(mem_rst_n), .mem_en(mem_en), .mem_load(mem_load),
   .ratio_sel(ratio_sel),
   .ctl_div_wave(ctl_div_wave), .ctl_div_tick(ctl_div_tick), .ctl_sel_err(ctl_sel_err),
   .mem_div_wave(mem_div_wave), .mem_div_tick(mem_div_tick), .mem_sel_err(mem_sel_err)
);

// File: tb/gear_ratio_div_tb_top.sv
`timescale 1ns/1ps
module gear_ratio_div_tb_top;
   localparam int CLK_UNIT = 1;   // ns per half-period step

   logic ctl_clk = 1'b0, mem_clk = 1'b0;
   int   ctl_half = 4 * CLK_UNIT, mem_half = 4 * CLK_UNIT;
   always #(ctl_half) ctl_clk = ~ctl_clk;
   always #(mem_half) mem_clk = ~mem_clk;

   logic ctl_rst_n = 1'b0, mem_rst_n = 1'b0;
   logic ctl_en = 1'b0, mem_en = 1'b0, ctl_load = 1'b0, mem_load = 1'b0;
   logic [2:0] ratio_sel = 3'd0;
   logic ctl_div_wave, ctl_div_tick, ctl_sel_err, mem_div_wave, mem_div_tick, mem_sel_err;

   gear_ratio_div dut_i (
      .ctl_clk(ctl_clk), .ctl_rst_n(ctl_rst_n), .ctl_en(ctl_en), .ctl_load(ctl_load),
      .mem_clk(mem_clk), .mem_rst_n(mem_rst_n), .mem_en(mem_en), .mem_load(mem_load),
      .ratio_sel(ratio_sel),
      .ctl_div_wave(ctl_div_wave), .ctl_div_tick(ctl_div_tick), .ctl_sel_err(ctl_sel_err),
      .mem_div_wave(mem_div_wave), .mem_div_tick(mem_div_tick), .mem_sel_err(mem_sel_err)
   );

   int n_run = 0, n_fail = 0;
   bit live_c = 0, live_m = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Gear table as stated in R2 and R8.
   function automatic int exp_m(input int c);
      case (c) 0: return 4; 1: return 4; 2: return 3; 3: return 4; 4: return 2; 5: return 8;
         default: return 1; endcase
   endfunction
   function automatic int exp_n(input int c);
      case (c) 0: return 4; 1: return 3; 2: return 2; 3: return 2; 4: return 2; 5: return 6;
         default: return 1; endcase
   endfunction

   // Behavioural lane models.
   int c_en, c_cnt, c_cur, c_pend, c_pv, c_err;
   int m_en, m_cnt, m_cur, m_pend, m_pv, m_err;

   always @(posedge ctl_clk) begin
      if (!ctl_rst_n) begin
         c_en = 0; c_cnt = 0; c_cur = 4; c_pend = 4; c_pv = 0; c_err = 0;
      end else begin
         if (c_en == 0 || c_cnt == c_cur - 1) begin
            c_cnt = 0;
            if (c_pv != 0) begin c_cur = c_pend; c_pv = 0; end
         end else c_cnt++;
         if (ctl_load) begin
            c_pend = exp_m(int'(ratio_sel)); c_pv = 1; c_err = (ratio_sel >= 6) ? 1 : 0;
         end
         c_en = int'(ctl_en);
      end
   end

   always @(posedge mem_clk) begin
      if (!mem_rst_n) begin
         m_en = 0; m_cnt = 0; m_cur = 4; m_pend = 4; m_pv = 0; m_err = 0;
      end else begin
         if (m_en == 0 || m_cnt == m_cur - 1) begin
            m_cnt = 0;
            if (m_pv != 0) begin m_cur = m_pend; m_pv = 0; end
         end else m_cnt++;
         if (mem_load) begin
            m_pend = exp_n(int'(ratio_sel)); m_pv = 1; m_err = (ratio_sel >= 6) ? 1 : 0;
         end
         m_en = int'(mem_en);
      end
   end

   int ctl_last = 0, ctl_ivl = 0, mem_last = 0, mem_ivl = 0;
   int ctl_high = 0, mem_high = 0;

   always @(negedge ctl_clk) begin
      if (live_c) begin
         int h;
         h = (c_cur == 1) ? 1 : c_cur / 2;
         chk("R4 R7 ctl tick", int'(ctl_div_tick), int'(c_en != 0 && c_cnt == 0));
         chk("R5 R7 ctl wave", int'(ctl_div_wave), int'(c_en != 0 && c_cnt < h));
         chk("R8 ctl err", int'(ctl_sel_err), c_err);
      end
      if (ctl_div_tick) begin ctl_ivl = int'($time) - ctl_last; ctl_last = int'($time); end
      if (ctl_div_wave) ctl_high++;
   end

   always @(negedge mem_clk) begin
      if (live_m) begin
         int h;
         h = (m_cur == 1) ? 1 : m_cur / 2;
         chk("R4 R7 mem tick", int'(mem_div_tick), int'(m_en != 0 && m_cnt == 0));
         chk("R5 R7 mem wave", int'(mem_div_wave), int'(m_en != 0 && m_cnt < h));
         chk("R8 mem err", int'(mem_sel_err), m_err);
      end
      if (mem_div_tick) begin mem_ivl = int'($time) - mem_last; mem_last = int'($time); end
      if (mem_div_wave) mem_high++;
   end

   task automatic load_both(input int c);
      @(negedge ctl_clk); ratio_sel = 3'(c); ctl_load = 1'b1;
      @(negedge ctl_clk); ctl_load = 1'b0;
      @(negedge mem_clk); ratio_sel = 3'(c); mem_load = 1'b1;
      @(negedge mem_clk); mem_load = 1'b0;
   endtask

   task automatic run_code(input int c);
      int m, n;
      m = exp_m(c); n = exp_n(c);
      ctl_half = n * CLK_UNIT; mem_half = m * CLK_UNIT;
      load_both(c);
      #(120 * m * n * CLK_UNIT);
      chk("R2 R3 ctl interval", ctl_ivl, 2 * m * n * CLK_UNIT);
      chk("R2 R3 mem interval", mem_ivl, 2 * m * n * CLK_UNIT);
      chk("R3 matched interval", ctl_ivl, mem_ivl);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_run++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge ctl_clk);
      chk("R1 reset ctl wave/tick/err", int'({ctl_div_wave, ctl_div_tick, ctl_sel_err}), 0);
      chk("R1 reset mem wave/tick/err", int'({mem_div_wave, mem_div_tick, mem_sel_err}), 0);
      @(negedge ctl_clk); ctl_rst_n = 1'b1; ctl_en = 1'b1; live_c = 1;
      @(negedge mem_clk); mem_rst_n = 1'b1; mem_en = 1'b1; live_m = 1;
      #400;
      chk("R1 default ctl interval", ctl_ivl, 32);
      chk("R1 default mem interval", mem_ivl, 32);

      for (int c = 1; c <= 5; c++) run_code(c);

      // Odd divisor duty: code 2, M=3 -> 1 high per 3, N=2 -> 1 high per 2.
      ctl_half = 2 * CLK_UNIT; mem_half = 3 * CLK_UNIT;
      load_both(2);
      #200;
      @(negedge ctl_clk); ctl_high = 0;
      repeat (30) @(negedge ctl_clk);
      chk("R5 ctl odd duty highs", ctl_high, 10);
      @(negedge mem_clk); mem_high = 0;
      repeat (30) @(negedge mem_clk);
      chk("R5 mem duty highs", mem_high, 15);

      // Unsupported code.
      load_both(6);
      #200;
      chk("R8 ctl err set", int'(ctl_sel_err), 1);
      chk("R8 mem err set", int'(mem_sel_err), 1);
      chk("R8 ctl divide by 1", ctl_ivl, 2 * ctl_half);
      chk("R8 mem divide by 1", mem_ivl, 2 * mem_half);
      @(negedge ctl_clk); ctl_high = 0;
      repeat (10) @(negedge ctl_clk);
      chk("R5 ctl D=1 wave high", ctl_high, 10);
      ctl_half = 4 * CLK_UNIT; mem_half = 4 * CLK_UNIT;
      load_both(0);
      #200;
      chk("R8 ctl err cleared", int'(ctl_sel_err), 0);
      chk("R8 mem err cleared", int'(mem_sel_err), 0);

      // Disable and restart, with a load applied while idle.
      @(negedge ctl_clk); ctl_en = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge ctl_clk);
         chk("R6 ctl idle wave/tick", int'({ctl_div_wave, ctl_div_tick}), 0);
      end
      ratio_sel = 3'd4; ctl_load = 1'b1;
      @(negedge ctl_clk); ctl_load = 1'b0; ctl_en = 1'b1;
      @(negedge ctl_clk); chk("R6 R7 ctl restart tick", int'(ctl_div_tick), 1);
      @(negedge ctl_clk); chk("R7 ctl idle load D=2 gap", int'(ctl_div_tick), 0);
      @(negedge ctl_clk); chk("R7 ctl idle load D=2 next", int'(ctl_div_tick), 1);

      @(negedge mem_clk); mem_en = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge mem_clk);
         chk("R6 mem idle wave/tick", int'({mem_div_wave, mem_div_tick}), 0);
      end
      @(negedge mem_clk); mem_en = 1'b1;
      @(negedge mem_clk); chk("R6 mem restart tick", int'(mem_div_tick), 1);
      #200;
      finish_run();
   end
endmodule